// File: doc/BRIEF.md
# Three-Backplane Multiplexed LCD Segment Driver

This block produces the digital drive-level codes for a liquid-crystal glass that is multiplexed over three backplanes. It takes four BCD digits, a leading half-digit "1", a minus sign, four decimal-point enables and two flag annunciators (continuity and low battery). From these it generates a level code for every backplane and every segment line. Each segment line serves three segments of one digit. The segment a line currently addresses is set by which backplane is active. A square-wave annunciator output runs at the frame rate. Analog level generation is left to the pad drivers that follow this block.

A frame lasts `DIV` clocks, which is 1200 clocks of the conversion oscillator by default. The frame is divided into three backplane slots. Each slot has a positive half and a negative half, so the average voltage across every segment is zero. Display data passes through a staging register that captures on a load strobe. The staged value is copied to the shown register only at a frame boundary, so a frame never mixes old and new digits.

Top module: `lcd3_drive`

## Requirements
- R1: A frame is `DIV` clocks long (`DIV` a multiple of 6). It consists of six phases of `DIV/6` clocks. Phase p covers slot p/2 in half p%2 (half 0 positive, half 1 negative). Reset starts the frame at phase 0. `ann_o` is 1 during phases 0 to 2 and 0 during phases 3 to 5, giving a square wave at the frame rate.
- R2: Level codes are 0 = bottom rail, 1 = low intermediate, 2 = high intermediate, 3 = top rail. Backplane k sits at `bp_lvl_o[2k+1:2k]`. The backplane active in the current slot drives 3 in half 0 and 0 in half 1. The other backplanes drive 1 in half 0 and 2 in half 1. None of this depends on the display data.
- R3: A segment line whose addressed segment is on drives 0 in half 0 and 3 in half 1. A line whose segment is off drives 2 in half 0 and 1 in half 1, so it only ever uses the intermediate levels.
- R4: Digit d (0 = least significant) owns three lines, found at `seg_lvl_o[(3d+l)*2 +: 2]`. Line 0 addresses segment b, then c, then the digit's extra symbol in slots 0, 1 and 2. Line 1 addresses a, then g, then d. Line 2 addresses f, then e, then the digit's decimal point.
- R5: The extra symbol is continuity (`cont_i`) on digit 0, low battery (`low_batt_i`) on digit 1, the minus sign (`minus_i`) on digit 2 and the half-digit "1" (`half_one_i`) on digit 3. Decimal point d is enabled by `dp_i[d]`.
- R6: BCD values 0 to 9 light the usual seven-segment patterns: 0 lights abcdef; 1 lights bc; 2 lights abdeg; 3 lights abcdg; 4 lights bcfg; 5 lights acdfg; 6 lights acdefg; 7 lights abc; 8 lights all seven; 9 lights abcdfg. Codes 10 to 15 light no segment.
- R7: A high `load_i` captures all data inputs into the staging register. The shown data changes only at the start of the first frame that begins after the load. Data inputs that change without `load_i` have no effect.
- R8: If several loads occur before a frame boundary, the next frame shows the values from the last load.
- R9: After reset, every digit is blank and every decimal point and extra symbol is off, so all segment lines show the off pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Display clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that captures the data inputs |
| digit_i | input | 16 | Four BCD digits, digit d at bits 4d+3:4d |
| dp_i | input | 4 | Decimal-point enables, one per digit |
| cont_i | input | 1 | Continuity annunciator on |
| low_batt_i | input | 1 | Low-battery annunciator on |
| minus_i | input | 1 | Minus sign on |
| half_one_i | input | 1 | Leading half-digit "1" on |
| bp_lvl_o | output | 6 | Level codes for the three backplanes |
| seg_lvl_o | output | 24 | Level codes for the twelve segment lines |
| ann_o | output | 1 | Annunciator square wave |

## Verification
The bench builds the main instance with `DIV = 12`. That gives two clocks per phase and a whole frame in twelve clocks, so every BCD code, every extra symbol and every load placement within a frame can be covered in a few hundred cycles. A second instance keeps the default `DIV = 1200`. It is used only to measure the annunciator's high time and period, which checks the frame length at its intended value. On the short frame, loads are placed in mid-frame and at two points within the same frame to show the boundary hand-over and the last-load-wins rule.

// File: rtl/lcd3_pkg.sv
`timescale 1ns/1ps
package lcd3_pkg;

    localparam int NUM_DIG = 4;
    localparam int NUM_BP  = 3;
    localparam int NUM_PH  = 2 * NUM_BP;
    localparam int LINES   = 3;

    typedef enum logic [1:0] {
        LV_BOT  = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_TOP  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic [NUM_DIG-1:0][3:0] dig;
        logic [NUM_DIG-1:0]      dp;
        logic [NUM_DIG-1:0]      ext;
    } disp_t;

    function automatic disp_t blank_disp();
        disp_t r;
        for (int i = 0; i < NUM_DIG; i++) r.dig[i] = 4'hF;
        r.dp  = '0;
        r.ext = '0;
        return r;
    endfunction

    // Segment vector ordering {g,f,e,d,c,b,a}
    function automatic logic [6:0] seg7(input logic [3:0] v);
        logic [6:0] s;
        case (v)
            4'd0:    s = 7'b0111111;
            4'd1:    s = 7'b0000110;
            4'd2:    s = 7'b1011011;
            4'd3:    s = 7'b1001111;
            4'd4:    s = 7'b1100110;
            4'd5:    s = 7'b1101101;
            4'd6:    s = 7'b1111101;
            4'd7:    s = 7'b0000111;
            4'd8:    s = 7'b1111111;
            4'd9:    s = 7'b1101111;
            default: s = 7'b0000000;
        endcase
        return s;
    endfunction

    function automatic lvl_e seg_level(input logic on, input logic neg);
        if (neg) return on ? LV_TOP : LV_LOW;
        return on ? LV_BOT : LV_HIGH;
    endfunction

    function automatic lvl_e bp_level(input logic active, input logic neg);
        if (neg) return active ? LV_BOT : LV_HIGH;
        return active ? LV_TOP : LV_LOW;
    endfunction

endpackage

// File: rtl/lcd3_timebase.sv
`timescale 1ns/1ps
module lcd3_timebase
    import lcd3_pkg::*;
#(
    parameter int DIV = 1200
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    output logic [2:0] ph_o,
    output logic       frame_end_o
);
    localparam int PH_LEN = DIV / NUM_PH;
    localparam int CW     = (PH_LEN > 1) ? $clog2(PH_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PH_LEN - 1);
    localparam logic [2:0]    PH_LAST  = 3'(NUM_PH - 1);

    typedef struct packed {
        logic [CW-1:0] pcnt;
        logic [2:0]    ph;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      frame_end_d;

    always_comb begin
        st_d        = st_q;
        frame_end_d = 1'b0;
        if (st_q.pcnt == CNT_LAST) begin
            st_d.pcnt = '0;
            if (st_q.ph == PH_LAST) begin
                st_d.ph     = '0;
                frame_end_d = 1'b1;
            end else begin
                st_d.ph = st_q.ph + 3'd1;
            end
        end else begin
            st_d.pcnt = st_q.pcnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ph_o        = st_q.ph;
    assign frame_end_o = frame_end_d;

    assert_phase_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pcnt != CNT_LAST) |=> $stable(st_q.ph));

    assert_frame_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_end_o |=> (st_q.ph == 3'd0));

endmodule

// File: rtl/lcd3_datareg.sv
`timescale 1ns/1ps
module lcd3_datareg
    import lcd3_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  load_i,
    input  logic  frame_end_i,
    input  disp_t new_i,
    output disp_t shown_o
);
    typedef struct packed {
        disp_t stage;
        disp_t shown;
        logic  pending;
    } dr_state_t;

    dr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end_i && st_q.pending) begin
            st_d.shown   = st_q.stage;
            st_d.pending = 1'b0;
        end
        if (load_i) begin
            st_d.stage   = new_i;
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.stage   <= blank_disp();
            st_q.shown   <= blank_disp();
            st_q.pending <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shown_o = st_q.shown;

    assert_hold_in_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_end_i |=> $stable(st_q.shown));

    assert_load_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (st_q.pending && st_q.stage == $past(new_i)));

endmodule

// File: rtl/lcd3_line_drv.sv
`timescale 1ns/1ps
module lcd3_line_drv
    import lcd3_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] bcd_i,
    input  logic       dp_i,
    input  logic       ext_i,
    input  logic [1:0] slot_i,
    input  logic       half_i,
    output logic [5:0] lvl_o
);
    logic [6:0]       seg;
    logic [LINES-1:0] on;

    always_comb begin
        seg = seg7(bcd_i);
        case (slot_i)
            2'd0:    on = {seg[5], seg[0], seg[1]};
            2'd1:    on = {seg[4], seg[6], seg[2]};
            default: on = {dp_i,   seg[3], ext_i};
        endcase
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        assign lvl_o[l*2 +: 2] = seg_level(on[l], half_i);
    end

    assert_off_levels_pos_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !half_i |-> (!lvl_o[0] && !lvl_o[2] && !lvl_o[4]));

    assert_off_levels_neg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        half_i |-> (lvl_o[0] && lvl_o[2] && lvl_o[4]));

endmodule

// File: rtl/lcd3_drive.sv
`timescale 1ns/1ps
module lcd3_drive
    import lcd3_pkg::*;
#(
    parameter int DIV = 1200
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   load_i,
    input  logic [NUM_DIG*4-1:0]   digit_i,
    input  logic [NUM_DIG-1:0]     dp_i,
    input  logic                   cont_i,
    input  logic                   low_batt_i,
    input  logic                   minus_i,
    input  logic                   half_one_i,
    output logic [NUM_BP*2-1:0]    bp_lvl_o,
    output logic [NUM_DIG*6-1:0]   seg_lvl_o,
    output logic                   ann_o
);
    logic [2:0]  ph;
    logic        frame_end;
    logic [1:0]  slot;
    logic        half;
    disp_t       new_data;
    disp_t       shown;
    logic [NUM_BP-1:0] at_rail;

    lcd3_timebase #(.DIV(DIV)) u_tb (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ph_o        (ph),
        .frame_end_o (frame_end)
    );

    always_comb begin
        new_data.dig = digit_i;
        new_data.dp  = dp_i;
        new_data.ext = {half_one_i, minus_i, low_batt_i, cont_i};
    end

    lcd3_datareg u_dr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load_i),
        .frame_end_i (frame_end),
        .new_i       (new_data),
        .shown_o     (shown)
    );

    assign slot  = ph[2:1];
    assign half  = ph[0];
    assign ann_o = (ph < 3'(NUM_PH / 2));

    for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
        assign bp_lvl_o[k*2 +: 2] = bp_level(slot == 2'(k), half);
        assign at_rail[k] = (bp_lvl_o[k*2 +: 2] == LV_TOP) ||
                            (bp_lvl_o[k*2 +: 2] == LV_BOT);
    end

    for (genvar d = 0; d < NUM_DIG; d++) begin : g_dig
        lcd3_line_drv u_line (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .bcd_i  (shown.dig[d]),
            .dp_i   (shown.dp[d]),
            .ext_i  (shown.ext[d]),
            .slot_i (slot),
            .half_i (half),
            .lvl_o  (seg_lvl_o[d*6 +: 6])
        );
    end

    assert_one_active_bp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(at_rail) == 1);

    assert_ann_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ann_o) |-> ($past(frame_end) && bp_lvl_o[1:0] == LV_TOP));

endmodule

// File: tb/lcd3_drive_tb_top.sv
`timescale 1ns/1ps
module lcd3_drive_tb_top;

    localparam int DIV_FAST = 12;
    localparam int PH_CYC   = DIV_FAST / 6;
    localparam int DIV_SLOW = 1200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] digit = '0;
    logic [3:0]  dp = '0;
    logic        cont = 1'b0, lbat = 1'b0, minus = 1'b0, half1 = 1'b0;
    logic [5:0]  bp_f, bp_s;
    logic [23:0] seg_f, seg_s;
    logic        ann_f, ann_s;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [15:0] e_dig;
    logic [3:0]  e_dp;
    logic [3:0]  e_ext;

    always #2.5 clk = ~clk;

    lcd3_drive #(.DIV(DIV_FAST)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .digit_i(digit), .dp_i(dp),
        .cont_i(cont), .low_batt_i(lbat), .minus_i(minus), .half_one_i(half1),
        .bp_lvl_o(bp_f), .seg_lvl_o(seg_f), .ann_o(ann_f)
    );

    lcd3_drive #(.DIV(DIV_SLOW)) dut_slow_i (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .digit_i(digit), .dp_i(dp),
        .cont_i(cont), .low_batt_i(lbat), .minus_i(minus), .half_one_i(half1),
        .bp_lvl_o(bp_s), .seg_lvl_o(seg_s), .ann_o(ann_s)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] v);
        // bits {g,f,e,d,c,b,a}, R6 patterns
        case (v)
            4'd0: ref_seg = 7'h3F; 4'd1: ref_seg = 7'h06; 4'd2: ref_seg = 7'h5B;
            4'd3: ref_seg = 7'h4F; 4'd4: ref_seg = 7'h66; 4'd5: ref_seg = 7'h6D;
            4'd6: ref_seg = 7'h7D; 4'd7: ref_seg = 7'h07; 4'd8: ref_seg = 7'h7F;
            4'd9: ref_seg = 7'h6F; default: ref_seg = 7'h00;
        endcase
    endfunction

    function automatic logic [1:0] ref_seg_lvl(input logic on, input logic h);
        if (h) ref_seg_lvl = on ? 2'd3 : 2'd1;
        else   ref_seg_lvl = on ? 2'd0 : 2'd2;
    endfunction

    task automatic cmp(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_phase(input string tag, input int p);
        int s = p / 2;
        logic h = logic'(p % 2);
        logic [5:0]  ebp;
        logic [23:0] eseg;
        for (int k = 0; k < 3; k++) begin
            if (k == s) ebp[k*2 +: 2] = h ? 2'd0 : 2'd3;
            else        ebp[k*2 +: 2] = h ? 2'd2 : 2'd1;
        end
        for (int d = 0; d < 4; d++) begin
            logic [6:0] sg = ref_seg(e_dig[d*4 +: 4]);
            logic o0, o1, o2;
            o0 = (s == 0) ? sg[1] : (s == 1) ? sg[2] : e_ext[d];
            o1 = (s == 0) ? sg[0] : (s == 1) ? sg[6] : sg[3];
            o2 = (s == 0) ? sg[5] : (s == 1) ? sg[4] : e_dp[d];
            eseg[(3*d+0)*2 +: 2] = ref_seg_lvl(o0, h);
            eseg[(3*d+1)*2 +: 2] = ref_seg_lvl(o1, h);
            eseg[(3*d+2)*2 +: 2] = ref_seg_lvl(o2, h);
        end
        cmp({tag, " R2 backplanes"}, {18'd0, bp_f}, {18'd0, ebp});
        cmp({tag, " R3/R4 segments"}, seg_f, eseg);
        cmp({tag, " R1 annunciator"}, {23'd0, ann_f}, {23'd0, logic'(p < 3)});
    endtask

    // Starts at the first negedge of a frame, ends at the first negedge of the next
    task automatic check_frame(input string tag);
        for (int p = 0; p < 6; p++) begin
            check_phase(tag, p);
            repeat (PH_CYC) @(negedge clk);
        end
    endtask

    task automatic drive(input logic [15:0] dg, input logic [3:0] dpv, input logic [3:0] ex);
        digit = dg; dp = dpv;
        cont = ex[0]; lbat = ex[1]; minus = ex[2]; half1 = ex[3];
    endtask

    // Load at frame start, then verify the following frame shows it
    task automatic load_and_show(input string tag, input logic [15:0] dg,
                                 input logic [3:0] dpv, input logic [3:0] ex);
        drive(dg, dpv, ex);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (DIV_FAST - 1) @(negedge clk);
        e_dig = dg; e_dp = dpv; e_ext = ex;
        check_frame(tag);
    endtask

    task automatic test_reset_R9();
        e_dig = 16'hFFFF; e_dp = '0; e_ext = '0;
        check_frame("R9 reset blank frame");
    endtask

    task automatic test_decode_R6();
        load_and_show("R6 digits 3210", 16'h3210, 4'b0000, 4'b0000);
        load_and_show("R6 digits 7654", 16'h7654, 4'b0000, 4'b0000);
        load_and_show("R6 digits BA98", 16'hBA98, 4'b0000, 4'b0000);
        load_and_show("R6 digits FEDC", 16'hFEDC, 4'b0000, 4'b0000);
    endtask

    task automatic test_extras_R5();
        load_and_show("R5 continuity", 16'h8888, 4'b0000, 4'b0001);
        load_and_show("R5 low battery", 16'h8888, 4'b0000, 4'b0010);
        load_and_show("R5 minus", 16'h1111, 4'b0000, 4'b0100);
        load_and_show("R5 half digit", 16'h0000, 4'b0000, 4'b1000);
        load_and_show("R5 dp pattern", 16'h5050, 4'b1010, 4'b0000);
        load_and_show("R4 all lit", 16'h8888, 4'b1111, 4'b1111);
    endtask

    task automatic test_midframe_R7();
        load_and_show("R7 base", 16'h1234, 4'b0001, 4'b0000);
        for (int p = 0; p < 6; p++) begin
            check_phase("R7 old frame kept", p);
            if (p == 2) begin
                drive(16'h9876, 4'b0100, 4'b0110);
                load = 1'b1;
                @(negedge clk);
                load = 1'b0;
                drive(16'h5555, 4'b1111, 4'b1111);
                @(negedge clk);
            end else begin
                repeat (PH_CYC) @(negedge clk);
            end
        end
        e_dig = 16'h9876; e_dp = 4'b0100; e_ext = 4'b0110;
        check_frame("R7 new frame, unloaded change ignored");
        check_frame("R7 still held");
    endtask

    task automatic test_last_wins_R8();
        for (int p = 0; p < 6; p++) begin
            check_phase("R8 prior frame", p);
            if (p == 1 || p == 4) begin
                if (p == 1) drive(16'h2222, 4'b0011, 4'b0001);
                else        drive(16'h0407, 4'b1000, 4'b1100);
                load = 1'b1;
                @(negedge clk);
                load = 1'b0;
                @(negedge clk);
            end else begin
                repeat (PH_CYC) @(negedge clk);
            end
        end
        e_dig = 16'h0407; e_dp = 4'b1000; e_ext = 4'b1100;
        check_frame("R8 last load shown");
    endtask

    task automatic test_slow_period_R1();
        int hi_cnt = 0;
        int per = 0;
        logic prv = ann_s;
        bit hit = 1'b0;
        while (!hit) begin
            @(negedge clk);
            if (!prv && ann_s) hit = 1'b1;
            prv = ann_s;
        end
        cmp("R1 slow frame start bp", {18'd0, bp_s}, {18'd0, 6'b01_01_11});
        while (ann_s) begin @(negedge clk); hi_cnt++; per++; end
        while (!ann_s) begin @(negedge clk); per++; end
        cmp("R1 slow ann high time", 24'(hi_cnt), 24'(DIV_SLOW / 2));
        cmp("R1 slow frame period", 24'(per), 24'(DIV_SLOW));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_R9();
        test_decode_R6();
        test_extras_R5();
        test_midframe_R7();
        test_last_wins_R8();
        test_slow_period_R1();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule